// File: doc/BRIEF.md
# Sticky Event Summary and Interrupt Register

This block gathers one-cycle event pulses from many sources into a single 16-bit summary register and raises interrupts from it. Alignment-change pulses from any number of receive ports fold into one flag and those from transmit ports into another. A small watcher turns the raw signals of a bit-error-rate tester (sync level, bit-error strobe, two counter-overflow strobes) into a single "major change" flag. Host-bus system errors and parity errors, and two local-bus events, each own a flag as well.

Every flag is sticky. A host read of the summary register returns the flags and clears them in the same access. A separate mask register chooses which flags may interrupt. Any enabled, set flag pulls the active-low host interrupt low. The same condition drives the local-bus interrupt, but only while the local bus is in configuration mode. Software reads the summary, then goes to the per-source registers (outside this block) to find the cause.

Top module: `evt_status_hub`

## Requirements
- R1: Any bit of `rxAlignEvt` sets summary bit 0. Any bit of `txAlignEvt` sets summary bit 1. The flag is visible on the edge that samples the pulse.
- R2: Summary bit 2 is set when `bertSync` differs from its value at the previous edge (either direction), or when `bertBitErr`, `bertBitCntOvf` or `bertErrCntOvf` is high. A steady `bertSync` with no strobes leaves the bit clear. The sync history resets to 0.
- R3: `busSysErr` sets bit 3 and `busParErr` sets bit 4. `lbEvt[0]` sets bit 14 and `lbEvt[1]` sets bit 15.
- R4: A read at offset `STAT_ADDR` (default 0x20) returns the flags held before the edge, on `rdData` in the same cycle. At that edge all flags clear.
- R5: An event that arrives in the same cycle as a status read leaves its flag set after the read. The read itself returns the older value.
- R6: Bits 5 to 13 of the summary always read 0. Writes to `STAT_ADDR` change nothing.
- R7: The mask register at `MASK_ADDR` (default 0x24) can be written and read back. It keeps only bits 0-4, 14 and 15, and a write takes effect at the edge.
- R8: `hostIntN` goes low one edge after (status AND mask) becomes nonzero. It returns high one edge after that value becomes zero.
- R9: `localInt` is high one edge after a cycle in which (status AND mask) is nonzero and `localCfgMode` is 1. Otherwise it is low.
- R10: Reset clears status and mask, drives `hostIntN` high and `localInt` low.
- R11: A read of any other offset returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxAlignEvt | input | NUM_RX | Per-receive-port alignment-change pulses |
| txAlignEvt | input | NUM_TX | Per-transmit-port alignment-change pulses |
| bertSync | input | 1 | Tester receive-sync level |
| bertBitErr | input | 1 | Tester bit-error strobe |
| bertBitCntOvf | input | 1 | Tester bit-counter overflow strobe |
| bertErrCntOvf | input | 1 | Tester error-counter overflow strobe |
| busSysErr | input | 1 | Host bus system-error pulse |
| busParErr | input | 1 | Host bus parity-error pulse |
| lbEvt | input | 2 | Local-bus event pulses (bit 0 to flag 14, bit 1 to flag 15) |
| localCfgMode | input | 1 | Local bus is in configuration mode |
| rdEn | input | 1 | Host read strobe |
| wrEn | input | 1 | Host write strobe |
| addr | input | ADDR_W | Register offset |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid in the cycle of `rdEn` |
| hostIntN | output | 1 | Active-low host interrupt |
| localInt | output | 1 | Local-bus interrupt |

## Verification
Sparse random pulses on every source are mixed with random reads, mask writes and mode changes. This catches flags that clear without a read or that survive one. Directed cases separate the sync-edge detection from the error strobes by holding sync steady, then toggling it. A pulse is landed in the very cycle of a read to tell "cleared then set" apart from "lost". The interrupt pins are tried with the mask on and off and with configuration mode on and off, which shows the mask gating and the local-mode gating as two separate effects.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int FLAG_W    = 16;
  localparam int RX_BIT    = 0;
  localparam int TX_BIT    = 1;
  localparam int BERT_BIT  = 2;
  localparam int SYS_BIT   = 3;
  localparam int PAR_BIT   = 4;
  localparam int LBERR_BIT = 14;
  localparam int LBINT_BIT = 15;

  localparam logic [FLAG_W-1:0] LIVE_MASK =
      (FLAG_W'(1) << RX_BIT)   | (FLAG_W'(1) << TX_BIT)   |
      (FLAG_W'(1) << BERT_BIT) | (FLAG_W'(1) << SYS_BIT)  |
      (FLAG_W'(1) << PAR_BIT)  | (FLAG_W'(1) << LBERR_BIT) |
      (FLAG_W'(1) << LBINT_BIT);

  typedef struct packed {
    logic rdStatus;
    logic rdMask;
    logic wrMask;
  } hubStrobes_t;
endpackage

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h24
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output hubStrobes_t       strb
);
  logic hitStat;
  logic hitMask;

  assign hitStat = (addr == STAT_ADDR);
  assign hitMask = (addr == MASK_ADDR);

  // Writes to the summary offset decode to nothing.
  always_comb begin
    strb          = '0;
    strb.rdStatus = rdEn & hitStat;
    strb.rdMask   = rdEn & hitMask;
    strb.wrMask   = wrEn & hitMask;
  end
endmodule

// File: rtl/evt_bert_watch.sv
module evt_bert_watch #(
  parameter int OVF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncLvl,
  input  logic             bitErr,
  input  logic [OVF_W-1:0] ovfStb,
  output logic             chgPulse,
  output logic             syncQ
);
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 1'b0;
    else       syncQ <= syncLvl;
  end

  assign chgPulse = (syncLvl ^ syncQ) | bitErr | (|ovfStb);
endmodule

// File: rtl/evt_status_dp.sv
module evt_status_dp
  import evt_status_pkg::*;
#(
  parameter int NUM_RX = 8,
  parameter int NUM_TX = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_RX-1:0] rxAlignEvt,
  input  logic [NUM_TX-1:0] txAlignEvt,
  input  logic              bertSync,
  input  logic              bertBitErr,
  input  logic              bertBitCntOvf,
  input  logic              bertErrCntOvf,
  input  logic              busSysErr,
  input  logic              busParErr,
  input  logic [1:0]        lbEvt,
  input  logic              localCfgMode,
  input  hubStrobes_t       strb,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] rdData,
  output logic              hostIntN,
  output logic              localInt,
  output logic [FLAG_W-1:0] statusQ,
  output logic [FLAG_W-1:0] maskQ,
  output logic [FLAG_W-1:0] setVec,
  output logic              syncQ
);
  localparam int OVF_W = 2;

  logic bertChg;
  logic pending;
  logic [NUM_RX:0] rxAny;
  logic [NUM_TX:0] txAny;

  // Ripple OR chains keep the fold explicit for any port count.
  assign rxAny[0] = 1'b0;
  assign txAny[0] = 1'b0;
  for (genvar i = 0; i < NUM_RX; i++) begin : g_rxFold
    assign rxAny[i+1] = rxAny[i] | rxAlignEvt[i];
  end
  for (genvar j = 0; j < NUM_TX; j++) begin : g_txFold
    assign txAny[j+1] = txAny[j] | txAlignEvt[j];
  end

  evt_bert_watch #(.OVF_W(OVF_W)) u_bertWatch (
    .clk      (clk),
    .rstN     (rstN),
    .syncLvl  (bertSync),
    .bitErr   (bertBitErr),
    .ovfStb   ({bertErrCntOvf, bertBitCntOvf}),
    .chgPulse (bertChg),
    .syncQ    (syncQ)
  );

  always_comb begin
    setVec            = '0;
    setVec[RX_BIT]    = rxAny[NUM_RX];
    setVec[TX_BIT]    = txAny[NUM_TX];
    setVec[BERT_BIT]  = bertChg;
    setVec[SYS_BIT]   = busSysErr;
    setVec[PAR_BIT]   = busParErr;
    setVec[LBERR_BIT] = lbEvt[0];
    setVec[LBINT_BIT] = lbEvt[1];
  end

  // A new event wins over the clear from a read in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)             statusQ <= '0;
    else if (strb.rdStatus) statusQ <= setVec;
    else                   statusQ <= statusQ | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (strb.wrMask) maskQ <= wrData & LIVE_MASK;
  end

  assign pending = |(statusQ & maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostIntN <= 1'b1;
      localInt <= 1'b0;
    end else begin
      hostIntN <= ~pending;
      localInt <= pending & localCfgMode;
    end
  end

  always_comb begin
    if (strb.rdStatus)    rdData = statusQ;
    else if (strb.rdMask) rdData = maskQ;
    else                  rdData = '0;
  end
endmodule

// File: rtl/evt_status_hub.sv
module evt_status_hub
  import evt_status_pkg::*;
#(
  parameter int NUM_RX = 8,
  parameter int NUM_TX = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_RX-1:0] rxAlignEvt,
  input  logic [NUM_TX-1:0] txAlignEvt,
  input  logic              bertSync,
  input  logic              bertBitErr,
  input  logic              bertBitCntOvf,
  input  logic              bertErrCntOvf,
  input  logic              busSysErr,
  input  logic              busParErr,
  input  logic [1:0]        lbEvt,
  input  logic              localCfgMode,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              hostIntN,
  output logic              localInt
);
  hubStrobes_t       strb;
  logic [FLAG_W-1:0] statusQ;
  logic [FLAG_W-1:0] maskQ;
  logic [FLAG_W-1:0] setVec;
  logic              syncQ;

  evt_status_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_ctrl (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  evt_status_dp #(.NUM_RX(NUM_RX), .NUM_TX(NUM_TX)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .rxAlignEvt    (rxAlignEvt),
    .txAlignEvt    (txAlignEvt),
    .bertSync      (bertSync),
    .bertBitErr    (bertBitErr),
    .bertBitCntOvf (bertBitCntOvf),
    .bertErrCntOvf (bertErrCntOvf),
    .busSysErr     (busSysErr),
    .busParErr     (busParErr),
    .lbEvt         (lbEvt),
    .localCfgMode  (localCfgMode),
    .strb          (strb),
    .wrData        (wrData),
    .rdData        (rdData),
    .hostIntN      (hostIntN),
    .localInt      (localInt),
    .statusQ       (statusQ),
    .maskQ         (maskQ),
    .setVec        (setVec),
    .syncQ         (syncQ)
  );
endmodule

// File: rtl/evt_status_hub_chk.sv
module evt_status_hub_chk
  import evt_status_pkg::*;
#(
  parameter int NUM_RX = 8,
  parameter int NUM_TX = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_RX-1:0] rxAlignEvt,
  input logic [NUM_TX-1:0] txAlignEvt,
  input logic              bertSync,
  input logic              syncQ,
  input logic [FLAG_W-1:0] statusQ,
  input logic [FLAG_W-1:0] maskQ,
  input logic [FLAG_W-1:0] setVec,
  input logic [15:0]       rdData,
  input logic              localCfgMode,
  input logic              hostIntN,
  input logic              localInt
);
  logic statRead;
  logic pend;

  assign statRead = rdEn && (addr == STAT_ADDR);
  assign pend     = |(statusQ & maskQ);

  assert_rx_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|rxAlignEvt) |=> statusQ[RX_BIT]);
  assert_tx_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|txAlignEvt) |=> statusQ[TX_BIT]);
  assert_sync_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bertSync != syncQ) |=> statusQ[BERT_BIT]);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    statRead |=> ((statusQ & ~$past(setVec)) == '0));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !statRead |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~LIVE_MASK) == '0) && ((rdData & ~LIVE_MASK) == '0));
  assert_mask_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ & ~LIVE_MASK) == '0);
  assert_int_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    pend |=> !hostIntN);
  assert_int_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pend |=> hostIntN);
  assert_local_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (localInt == $past(pend && localCfgMode)));
endmodule

bind evt_status_hub evt_status_hub_chk #(
  .NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rdEn         (rdEn),
  .addr         (addr),
  .rxAlignEvt   (rxAlignEvt),
  .txAlignEvt   (txAlignEvt),
  .bertSync     (bertSync),
  .syncQ        (syncQ),
  .statusQ      (statusQ),
  .maskQ        (maskQ),
  .setVec       (setVec),
  .rdData       (rdData),
  .localCfgMode (localCfgMode),
  .hostIntN     (hostIntN),
  .localInt     (localInt)
);

// File: tb/evt_status_hub_bench.sv
`timescale 1ns/1ps
module evt_status_hub_bench;
  localparam int NRX = 8;
  localparam int NTX = 8;
  localparam logic [7:0] SA = 8'h20;
  localparam logic [7:0] MA = 8'h24;
  localparam logic [15:0] LIVE = 16'hC01F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NRX-1:0] rxAlignEvt = '0;
  logic [NTX-1:0] txAlignEvt = '0;
  logic bertSync = 0, bertBitErr = 0, bertBitCntOvf = 0, bertErrCntOvf = 0;
  logic busSysErr = 0, busParErr = 0, localCfgMode = 0;
  logic [1:0] lbEvt = '0;
  logic rdEn = 0, wrEn = 0;
  logic [7:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic hostIntN, localInt;

  int checks = 0;
  int fails = 0;

  logic [15:0] mStat = '0, mMask = '0;
  logic mSync = 0, mHostN = 1, mLocal = 0;
  logic [15:0] lastRd;

  always #2.5 clk = ~clk;

  evt_status_hub u_evt_status_hub (
    .clk(clk), .rstN(rstN), .rxAlignEvt(rxAlignEvt), .txAlignEvt(txAlignEvt),
    .bertSync(bertSync), .bertBitErr(bertBitErr), .bertBitCntOvf(bertBitCntOvf),
    .bertErrCntOvf(bertErrCntOvf), .busSysErr(busSysErr), .busParErr(busParErr),
    .lbEvt(lbEvt), .localCfgMode(localCfgMode), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .hostIntN(hostIntN),
    .localInt(localInt)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expSet();
    logic [15:0] s = '0;
    s[0]  = |rxAlignEvt;
    s[1]  = |txAlignEvt;
    s[2]  = (bertSync != mSync) | bertBitErr | bertBitCntOvf | bertErrCntOvf;
    s[3]  = busSysErr;
    s[4]  = busParErr;
    s[14] = lbEvt[0];
    s[15] = lbEvt[1];
    return s;
  endfunction

  function automatic logic [15:0] expRead();
    if (!rdEn) return '0;
    if (addr == SA) return mStat;
    if (addr == MA) return mMask;
    return '0;
  endfunction

  // One clock: inputs already driven just after the previous edge.
  task automatic step();
    logic [15:0] s;
    #1;
    if (rdEn) begin
      lastRd = rdData;
      chk(addr == SA ? "R4 read" : (addr == MA ? "R7 read" : "R11 read"), rdData, expRead());
    end
    s = expSet();
    @(posedge clk);
    mHostN = ~|(mStat & mMask);
    mLocal = (|(mStat & mMask)) & localCfgMode;
    mStat  = ((rdEn && addr == SA) ? 16'h0 : mStat) | s;
    if (wrEn && addr == MA) mMask = wrData & LIVE;
    mSync  = bertSync;
    #1;
    chk("R8 hostIntN", {15'd0, hostIntN}, {15'd0, mHostN});
    chk("R9 localInt", {15'd0, localInt}, {15'd0, mLocal});
    rdEn = 0; wrEn = 0; rxAlignEvt = '0; txAlignEvt = '0;
    bertBitErr = 0; bertBitCntOvf = 0; bertErrCntOvf = 0;
    busSysErr = 0; busParErr = 0; lbEvt = '0;
  endtask

  task automatic rdStat(output logic [15:0] v);
    rdEn = 1; addr = SA; step(); v = lastRd;
  endtask

  task automatic wrMaskReg(input logic [15:0] d);
    wrEn = 1; addr = MA; wrData = d; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    // R10 reset state
    chk("R10 hostIntN", {15'd0, hostIntN}, 16'd1);
    chk("R10 localInt", {15'd0, localInt}, 16'd0);
    rdStat(v); chk("R10 status", v, 16'h0);
    rdEn = 1; addr = MA; step(); chk("R10 mask", lastRd, 16'h0);

    // R1
    rxAlignEvt[5] = 1; step();
    rdStat(v); chk("R1 rx summary", v, 16'h0001);
    rdStat(v); chk("R4 cleared", v, 16'h0000);
    txAlignEvt[NTX-1] = 1; step();
    rdStat(v); chk("R1 tx summary", v, 16'h0002);

    // R2
    bertSync = 1; step();
    rdStat(v); chk("R2 sync rise", v, 16'h0004);
    repeat (3) step();
    rdStat(v); chk("R2 steady sync", v, 16'h0000);
    bertSync = 0; step();
    rdStat(v); chk("R2 sync fall", v, 16'h0004);
    bertBitErr = 1; step(); rdStat(v); chk("R2 bit error", v, 16'h0004);
    bertBitCntOvf = 1; step(); rdStat(v); chk("R2 bit ovf", v, 16'h0004);
    bertErrCntOvf = 1; step(); rdStat(v); chk("R2 err ovf", v, 16'h0004);

    // R3
    busSysErr = 1; step(); busParErr = 1; step();
    lbEvt = 2'b01; step(); lbEvt = 2'b10; step();
    rdStat(v); chk("R3 bus and local flags", v, 16'hC018);

    // R5 event same cycle as read
    busSysErr = 1; step();
    rdEn = 1; addr = SA; rxAlignEvt[0] = 1; step();
    chk("R5 read returns old", lastRd, 16'h0008);
    rdStat(v); chk("R5 event kept", v, 16'h0001);

    // R6 status writes ignored
    wrEn = 1; addr = SA; wrData = 16'hFFFF; step();
    rdStat(v); chk("R6 write ignored", v, 16'h0000);

    // R7 mask
    wrMaskReg(16'hFFFF);
    rdEn = 1; addr = MA; step(); chk("R7 mask legal bits", lastRd, 16'hC01F);
    wrMaskReg(16'h0001);

    // R8 / R9
    localCfgMode = 0;
    txAlignEvt[0] = 1; step(); step();
    chk("R8 unmasked flag no int", {15'd0, hostIntN}, 16'd1);
    rxAlignEvt[2] = 1; step(); step();
    chk("R8 masked flag int", {15'd0, hostIntN}, 16'd0);
    chk("R9 local gated off", {15'd0, localInt}, 16'd0);
    localCfgMode = 1; step(); step();
    chk("R9 local on", {15'd0, localInt}, 16'd1);
    rdStat(v); step();
    chk("R8 int released", {15'd0, hostIntN}, 16'd1);

    // R11
    rxAlignEvt[1] = 1; step();
    rdEn = 1; addr = 8'h30; step(); chk("R11 unmapped", lastRd, 16'h0);
    rdStat(v); chk("R11 no clear", v, 16'h0001);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      rxAlignEvt    = (($urandom % 8) == 0) ? NRX'(1) << ($urandom % NRX) : '0;
      txAlignEvt    = (($urandom % 8) == 0) ? NTX'(1) << ($urandom % NTX) : '0;
      if (($urandom % 10) == 0) bertSync = ~bertSync;
      bertBitErr    = (($urandom % 16) == 0);
      bertBitCntOvf = (($urandom % 32) == 0);
      bertErrCntOvf = (($urandom % 32) == 0);
      busSysErr     = (($urandom % 20) == 0);
      busParErr     = (($urandom % 20) == 0);
      lbEvt         = 2'(($urandom % 16) == 0 ? $urandom : 0);
      if (($urandom % 25) == 0) localCfgMode = ~localCfgMode;
      case ($urandom % 6)
        0: begin rdEn = 1; addr = SA; end
        1: begin rdEn = 1; addr = MA; end
        2: begin wrEn = 1; addr = (($urandom % 2) == 0) ? MA : SA; wrData = 16'($urandom); end
        3: begin rdEn = 1; addr = 8'($urandom); end
        default: begin end
      endcase
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule